// File: doc/BRIEF.md
# HDLC Inter-Frame Flag Gap Inserter

This block sits in an HDLC transmit path between the frame source and the serializer. It sets how many flag bytes (0x7E) are sent between two frames. When the frame source reports that a frame has ended, the block works out a gap length from three static configuration inputs and latches it. The inputs are an 8-bit gap field, an absolute-gap enable and a scale select. The block then offers that many flag bytes on a byte-wide valid/ready output. Only after the last of those flags has been accepted does it grant the start of the next frame.

While no frame is waiting, the block keeps sending idle flags. When a frame is waiting and no idle flag is left unaccepted, the block raises a one-cycle grant and goes quiet until the frame ends. While a frame is running, the byte path belongs to the frame source, so the block drives no valid bytes.

Top module: `hdlc_gap_inserter`

## Requirements
- R1: After reset the block is ready for a frame. With `frm_avail` low it offers idle flags. With `frm_avail` high it raises `tx_grant` in the same cycle.
- R2: With `cfg_abs_en` low, exactly one flag is accepted between a frame end and the next grant.
- R3: With `cfg_abs_en` high and `cfg_scale` low, the number of flags between frames equals `cfg_gap`. A field of 0 gives no flags and 255 gives 255.
- R4: With `cfg_abs_en` and `cfg_scale` both high and `cfg_gap` nonzero, the number of flags equals `cfg_gap` times 256.
- R5: With `cfg_abs_en` and `cfg_scale` both high and `cfg_gap` equal to 0, exactly 65536 flags are sent.
- R6: Every byte offered with `out_valid` high is 0x7E. While a frame is in progress (from grant to `frm_end`), `out_valid` stays low.
- R7: A gap flag counts only when it is accepted (`out_valid` and `out_ready` both high). `tx_grant` stays low until the full count has been accepted, however `out_ready` is throttled.
- R8: After the gap has elapsed and while `frm_avail` is low, idle flags continue to be offered and accepted, one per accepted cycle.
- R9: The configuration is latched in the cycle `frm_end` is seen. Changing it during the gap does not change that gap's length.
- R10: Once `out_valid` is high and `out_ready` is low, `out_valid` stays high in the next cycle. An offered flag is never withdrawn.
- R11: `tx_grant` is only high while `frm_avail` is high. It lasts one cycle and does not come again before the next frame end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_gap | input | 8 | Gap length field |
| cfg_abs_en | input | 1 | Use the gap field; when low, the gap is one flag |
| cfg_scale | input | 1 | Multiply the field by 256; a field of zero means 65536 |
| frm_avail | input | 1 | A frame is waiting in the transmit FIFO |
| frm_end | input | 1 | One-cycle pulse: the running frame has ended |
| tx_grant | output | 1 | One-cycle pulse: the waiting frame may start |
| out_data | output | 8 | Flag byte toward the serializer |
| out_valid | output | 1 | `out_data` is offered |
| out_ready | input | 1 | Serializer accepts the offered byte |

## Verification
The raw-count mode is swept over every field value from 0 to 255, counting accepted flags between frame end and grant. This separates an off-by-one count, a wrong mode path and a missing zero case. Scaled mode is tried with fields of 1, 2 and 3, and with 0 to reach the 65536 wrap. This separates a correct multiply from a truncated counter. Throttled `out_ready` patterns show that only accepted flags are counted. A mid-gap configuration change and a long no-frame stretch separate latching from live use of the inputs, and idle flags from gap flags.

// File: rtl/hgap_pkg.sv
// Shared types and constants for the HDLC flag gap inserter.
package hgap_pkg;
    // Sequencer phases: waiting for a frame, frame running, sending the gap.
    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_FRAME = 2'd1,
        ST_GAP   = 2'd2
    } gap_state_t;

    localparam logic [7:0] FLAG_BYTE = 8'h7E;
endpackage

// File: rtl/hgap_len_calc.sv
// Gap length decoder.
// Turns the static configuration into the number of flags for one gap.
// Assumes CNT_W >= FIELD_W + SCALE_SH + 1, so that a zero field in
// scaled mode (2**(FIELD_W+SCALE_SH)) fits.
module hgap_len_calc #(
    parameter int FIELD_W  = 8,
    parameter int SCALE_SH = 8,
    parameter int CNT_W    = FIELD_W + SCALE_SH + 1
) (
    input  logic [FIELD_W-1:0] field,
    input  logic               abs_en,
    input  logic               scale,
    output logic [CNT_W-1:0]   gap_len
);
    localparam int WRAP_POS = FIELD_W + SCALE_SH;

    // Pick the gap length for the current configuration.
    always_comb begin
        if (!abs_en) begin
            gap_len = CNT_W'(1);
        end else if (scale) begin
            if (field == '0) gap_len = CNT_W'(1) << WRAP_POS;
            else             gap_len = CNT_W'(field) << SCALE_SH;
        end else begin
            gap_len = CNT_W'(field);
        end
    end
endmodule

// File: rtl/hgap_counter.sv
// Remaining-flag counter.
// Loads the latched gap length and counts down by one for each accepted
// flag. Assumes load and dec are never high together.
module hgap_counter #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] remain,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Hold, reload or decrement the remaining count.
    always_ff @(posedge clk) begin
        if (!rst_n)             remain <= '0;
        else if (load)          remain <= load_val;
        else if (dec && remain != '0) remain <= remain - ONE;
    end

    // Flag the final flag of the gap.
    always_comb last = (remain == ONE);

    a_r9_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> remain == $past(load_val));
    a_r7_dec_one: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && remain != '0) |=> remain == $past(remain) - ONE);
endmodule

// File: rtl/hdlc_gap_inserter.sv
// HDLC inter-frame flag gap inserter.
// Sends a configurable number of 0x7E flags after each frame end, and keeps
// sending idle flags while no frame waits. Grants the next frame only once
// the whole gap has been accepted downstream. Assumes the frame source
// owns the byte path between tx_grant and frm_end, and that the
// configuration inputs are quasi-static (they are latched at frame end).
module hdlc_gap_inserter
    import hgap_pkg::*;
#(
    parameter int FIELD_W  = 8,
    parameter int SCALE_SH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] cfg_gap,
    input  logic               cfg_abs_en,
    input  logic               cfg_scale,
    input  logic               frm_avail,
    input  logic               frm_end,
    output logic               tx_grant,
    output logic [7:0]         out_data,
    output logic               out_valid,
    input  logic               out_ready
);
    localparam int CNT_W = FIELD_W + SCALE_SH + 1;

    gap_state_t       state, state_nx;
    logic [CNT_W-1:0] gap_len;
    logic [CNT_W-1:0] remain;
    logic             last;
    logic             load;
    logic             dec;
    logic             pend;

    hgap_len_calc #(
        .FIELD_W (FIELD_W),
        .SCALE_SH(SCALE_SH),
        .CNT_W   (CNT_W)
    ) i_len (
        .field  (cfg_gap),
        .abs_en (cfg_abs_en),
        .scale  (cfg_scale),
        .gap_len(gap_len)
    );

    hgap_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .load_val(gap_len),
        .dec     (dec),
        .remain  (remain),
        .last    (last)
    );

    // Output offer, grant and counter controls for the current phase.
    always_comb begin
        out_data  = FLAG_BYTE;
        out_valid = 1'b0;
        tx_grant  = 1'b0;
        load      = 1'b0;
        dec       = 1'b0;
        state_nx  = state;
        case (state)
            ST_READY: begin
                out_valid = !frm_avail || pend;
                tx_grant  = frm_avail && !pend;
                if (tx_grant) state_nx = ST_FRAME;
            end
            ST_FRAME: begin
                if (frm_end) begin
                    load     = 1'b1;
                    state_nx = (gap_len == '0) ? ST_READY : ST_GAP;
                end
            end
            ST_GAP: begin
                out_valid = 1'b1;
                dec       = out_ready;
                if (out_ready && last) state_nx = ST_READY;
            end
            default: state_nx = ST_READY;
        endcase
    end

    // Advance the phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_READY;
        else        state <= state_nx;
    end

    // Remember an idle flag that was offered but not yet accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= (state == ST_READY) && out_valid && !out_ready;
    end

    a_r10_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid);
    a_r11_grant_needs_avail: assert property (@(posedge clk) disable iff (!rst_n)
        tx_grant |-> frm_avail);
    a_r11_grant_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_grant |=> !tx_grant);
    a_r7_no_grant_mid_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (remain != '0) |-> !tx_grant);
    a_r6_quiet_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        tx_grant |=> !out_valid);
endmodule

// File: tb/test_hdlc_gap_inserter.sv
module test_hdlc_gap_inserter;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 199000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_gap = '0;
    logic       cfg_abs_en = 1'b0;
    logic       cfg_scale = 1'b0;
    logic       frm_avail = 1'b0;
    logic       frm_end = 1'b0;
    logic       tx_grant;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_ready = 1'b1;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    hdlc_gap_inserter i_hdlc_gap_inserter (
        .clk(clk), .rst_n(rst_n), .cfg_gap(cfg_gap), .cfg_abs_en(cfg_abs_en),
        .cfg_scale(cfg_scale), .frm_avail(frm_avail), .frm_end(frm_end),
        .tx_grant(tx_grant), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WD_LIMIT && !done) begin
            done = 1'b1;
            failures = failures + 1;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    function automatic int exp_len(bit en, bit sc, int fld);
        if (!en) return 1;
        if (sc)  return (fld == 0) ? 65536 : fld * 256;
        return fld;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Entered in the cycle after a grant (frame running). Ends a frame with
    // the given configuration, then counts accepted flags until the next grant.
    // rmode 0: always ready; 1: ready two cycles in three; 2: ready one in four.
    // hold: frm_avail stays low until this many flags have been accepted.
    task automatic frame_gap(bit en, bit sc, int fld, int rmode, bit chg,
                             int hold, output int n, output int bad);
        int i;
        @(negedge clk);
        frm_avail  = 1'b0;
        cfg_abs_en = en; cfg_scale = sc; cfg_gap = 8'(fld);
        #1;
        bad = out_valid ? 1 : 0;
        frm_end = 1'b1;
        @(negedge clk);
        frm_end = 1'b0;
        if (chg) begin cfg_abs_en = 1'b1; cfg_scale = 1'b0; cfg_gap = 8'd200; end
        n = 0; i = 0;
        forever begin
            case (rmode)
                1:       out_ready = (i % 3) != 0;
                2:       out_ready = (i % 4) == 0;
                default: out_ready = 1'b1;
            endcase
            frm_avail = (n >= hold);
            #1;
            if (out_valid && out_data != 8'h7E) bad++;
            if (out_valid && out_ready) n++;
            if (tx_grant) break;
            i++;
            @(negedge clk);
        end
        out_ready = 1'b1;
    endtask

    initial begin
        int n, bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        frm_avail = 1'b0;
        #1;
        check(out_valid && !tx_grant && out_data == 8'h7E, "R1 idle after reset",
              {out_valid, tx_grant}, 2);
        @(negedge clk);
        frm_avail = 1'b1;
        #1;
        check(tx_grant == 1'b1, "R1 grant after reset", tx_grant, 1);

        // R2: enable low gives one flag, whatever the field and scale bits say
        frame_gap(1'b0, 1'b1, 37, 0, 1'b0, 0, n, bad);
        check(n == 1, "R2 abs disabled", n, 1);
        check(bad == 0, "R6 flag value / quiet frame", bad, 0);

        // R3: full raw sweep
        for (int f = 0; f < 256; f++) begin
            frame_gap(1'b1, 1'b0, f, 0, 1'b0, 0, n, bad);
            check(n == exp_len(1'b1, 1'b0, f) && bad == 0, "R3 raw count", n, f);
        end

        // R4: scaled nonzero fields
        for (int f = 1; f < 4; f++) begin
            frame_gap(1'b1, 1'b1, f, 0, 1'b0, 0, n, bad);
            check(n == f * 256, "R4 scaled count", n, f * 256);
        end

        // R5: scaled zero
        frame_gap(1'b1, 1'b1, 0, 0, 1'b0, 0, n, bad);
        check(n == 65536, "R5 scaled zero", n, 65536);
        check(bad == 0, "R6 flag value in long gap", bad, 0);

        // R7: throttled ready
        frame_gap(1'b1, 1'b0, 17, 1, 1'b0, 0, n, bad);
        check(n == 17, "R7 throttle 2/3", n, 17);
        frame_gap(1'b1, 1'b0, 9, 2, 1'b0, 0, n, bad);
        check(n == 9, "R7 throttle 1/4", n, 9);
        frame_gap(1'b1, 1'b1, 1, 2, 1'b0, 0, n, bad);
        check(n == 256, "R7 throttled scaled", n, 256);

        // R9: config change during gap ignored
        frame_gap(1'b1, 1'b0, 5, 0, 1'b1, 0, n, bad);
        check(n == 5, "R9 latched config", n, 5);
        frame_gap(1'b0, 1'b0, 0, 0, 1'b1, 0, n, bad);
        check(n == 1, "R9 latched disable", n, 1);

        // R8: idle flags continue after the gap
        frame_gap(1'b1, 1'b0, 4, 0, 1'b0, 4 + 30, n, bad);
        check(n == 34, "R8 idle flags", n, 34);
        frame_gap(1'b1, 1'b0, 0, 0, 1'b0, 12, n, bad);
        check(n == 12, "R8 idle after zero gap", n, 12);

        // R10/R11: held idle flag delays grant until accepted
        @(negedge clk);
        frm_avail = 1'b0;
        frm_end = 1'b1;
        cfg_abs_en = 1'b1; cfg_scale = 1'b0; cfg_gap = 8'd0;
        @(negedge clk);
        frm_end = 1'b0;
        out_ready = 1'b0;
        #1;
        check(out_valid == 1'b1, "R10 idle offered", out_valid, 1);
        @(negedge clk);
        frm_avail = 1'b1;
        #1;
        check(out_valid == 1'b1 && tx_grant == 1'b0, "R10 offer held, R11 no grant",
              {out_valid, tx_grant}, 2);
        out_ready = 1'b1;
        @(negedge clk);
        #1;
        check(tx_grant == 1'b1 && out_valid == 1'b0, "R11 grant after accept",
              {out_valid, tx_grant}, 1);
        @(negedge clk);
        #1;
        check(tx_grant == 1'b0 && out_valid == 1'b0, "R11 single grant, R6 quiet",
              {out_valid, tx_grant}, 0);
        repeat (3) @(negedge clk);
        #1;
        check(tx_grant == 1'b0, "R11 no grant before frame end", tx_grant, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule